// File: doc/BRIEF.md
# Packed String Compare Unit

This unit compares two 128-bit operands that each hold a short string of characters. The first operand is a set, a list of bound pairs or a needle, depending on the method. The second operand is always the haystack that is searched. An 8-bit control byte chooses the element type (bytes or words, signed or unsigned) and one of four matching methods. The four methods are set membership, inclusive ranges, position-by-position equality and substring start search. Each operand's valid length comes from one of two sources. In explicit mode it comes from a 32-bit signed length input. In implicit mode it ends at the operand's first zero element.

The per-position match vector is returned in one of two forms. In index form it is reduced to the position of its lowest or highest set bit. In mask form it comes back as a packed bit mask or as an element-wide expanded mask. A request pulse captures all inputs. The result appears with a one-cycle valid pulse after the following clock edge.

The control is a two-state machine. IDLE means no captured request. EVAL means a captured request is being evaluated. A request moves either state to EVAL (IDLE→EVAL, EVAL→EVAL when requests arrive back to back). A cycle without a request moves either state to IDLE (EVAL→IDLE, IDLE→IDLE). Leaving EVAL writes the result registers and raises the valid flag.

Top module: `pstr_match_unit`

## Requirements
- R1: Control bits [1:0] give the element type: 00 unsigned byte, 01 unsigned word, 10 signed byte, 11 signed word. Byte operands hold 16 elements (element k at bits 8k+7:8k), word operands hold 8 elements (element k at bits 16k+15:16k).
- R2: Method 00 in control bits [3:2] (set match) marks haystack position j when j is inside the haystack length and the element at j equals any first-operand element inside the first length.
- R3: Method 01 (ranges) treats first-operand elements 2p and 2p+1 as an inclusive lower and upper bound. A pair takes part only if both of its elements lie inside the first length. Position j is marked when it is inside the haystack length and within some pair's bounds.
- R4: Method 10 (equal-each) marks position j when both strings are valid at j and their elements are equal, and also when both strings have ended at j. When only one string has ended at j, the position is not marked.
- R5: Method 11 (equal-ordered) marks j when every needle element k inside the needle length equals haystack element j+k. A needle element that lands at or past the haystack length fails, so a needle of length 0 marks every position.
- R6: With implicit_len at 0, the lengths are the absolute values of len_a and len_b, saturated at the element count (16 for bytes, 8 for words).
- R7: With implicit_len at 1, each operand's length is the index of its first zero element, or the element count if it has none.
- R8: With mask_form at 0, res_idx is the lowest set match position when control bit 6 is 0 and the highest when it is 1. It is the element count when nothing matches. res_mask is 0.
- R9: With mask_form at 1, control bit 6 = 0 gives the packed match bits in res_mask[15:0] (bit j for element j, bits above the element count zero). Bit 6 = 1 sets every bit of each matching element's field and clears the rest. res_idx is 0.
- R10: A req sampled at clock edge k gives res_valid high for exactly the cycle after edge k+1, carrying that request's result. A request in every cycle gives a result in every cycle. The result registers hold their value until the next result.
- R11: A synchronous reset drives res_valid, res_idx and res_mask to 0 and drops any request in flight.
- R12: Signed types order elements as two's complement and unsigned types as plain binary. This changes the outcome of range checks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req | input | 1 | Request; captures all data inputs on this edge |
| ctrl | input | 8 | Control byte: [1:0] type, [3:2] method, [6] first/last or packed/expanded |
| opnd_a | input | 128 | First operand: set, bound pairs or needle |
| opnd_b | input | 128 | Second operand: haystack |
| len_a | input | 32 | Signed explicit length of opnd_a |
| len_b | input | 32 | Signed explicit length of opnd_b |
| implicit_len | input | 1 | 1: lengths end at first zero element; 0: use len_a/len_b |
| mask_form | input | 1 | 1: mask result; 0: index result |
| res_valid | output | 1 | One-cycle result strobe |
| res_idx | output | 5 | Index result |
| res_mask | output | 128 | Mask result |

## Verification
Two functions can fall in the same cycle. A new request can be captured in the same cycle that the previous one is evaluated, and a reset can arrive while a captured request is waiting in EVAL. The bench provokes the first with requests on two consecutive edges and expects two consecutive valid results, each carrying its own request's values. It provokes the second by raising reset in the cycle after a request and expects the outputs to stay cleared, with no stray valid pulse afterwards.

// File: rtl/pstr_pkg.sv
package pstr_pkg;
    parameter int OPND_W = 128;
    localparam int NB   = OPND_W / 8;
    localparam int NW   = NB / 2;
    localparam int IDXW = $clog2(NB + 1);
    localparam int LENW = 32;
    localparam int ELW  = 17;

    typedef enum logic [1:0] {
        M_ANY   = 2'b00,
        M_RANGE = 2'b01,
        M_EACH  = 2'b10,
        M_ORDER = 2'b11
    } method_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EVAL = 1'b1
    } state_e;

    // Element k of an operand, extended to a common signed width.
    function automatic logic signed [ELW-1:0] elem_val(
        input logic [OPND_W-1:0] v,
        input int                k,
        input logic              word,
        input logic              sgn
    );
        logic [15:0] raw;
        if (word) begin
            raw = v[16*(k % NW) +: 16];
            return sgn ? {raw[15], raw} : {1'b0, raw};
        end
        raw = {8'h00, v[8*(k % NB) +: 8]};
        return sgn ? {{9{raw[7]}}, raw[7:0]} : {9'b0, raw[7:0]};
    endfunction
endpackage

// File: rtl/pstr_len.sv
module pstr_len
    import pstr_pkg::*;
(
    input  logic [OPND_W-1:0] opnd,
    input  logic              word,
    input  logic              implicit_len,
    input  logic [LENW-1:0]   len_in,
    output logic [IDXW-1:0]   len_out
);
    logic [IDXW-1:0] cnt;
    logic [IDXW-1:0] zpos;
    logic [LENW-1:0] mag;

    always_comb begin
        cnt  = word ? IDXW'(NW) : IDXW'(NB);
        mag  = len_in[LENW-1] ? (~len_in + LENW'(1)) : len_in;
        zpos = cnt;
        for (int k = NB - 1; k >= 0; k--) begin
            if (k < int'(cnt) && elem_val(opnd, k, word, 1'b0) == '0)
                zpos = IDXW'(k);
        end
        if (implicit_len)
            len_out = zpos;
        else if (mag >= LENW'(cnt))
            len_out = cnt;
        else
            len_out = mag[IDXW-1:0];
    end
endmodule

// File: rtl/pstr_cmp.sv
module pstr_cmp
    import pstr_pkg::*;
(
    input  logic [OPND_W-1:0] opnd_a,
    input  logic [OPND_W-1:0] opnd_b,
    input  logic              word,
    input  logic              sgn,
    input  method_e           meth,
    input  logic [IDXW-1:0]   len_a,
    input  logic [IDXW-1:0]   len_b,
    output logic [NB-1:0]     hits
);
    logic signed [ELW-1:0] va [NB];
    logic signed [ELW-1:0] vb [NB];
    int la, lb, cnt;

    always_comb begin
        la  = int'(len_a);
        lb  = int'(len_b);
        cnt = word ? NW : NB;
        for (int k = 0; k < NB; k++) begin
            va[k] = elem_val(opnd_a, k, word, sgn);
            vb[k] = elem_val(opnd_b, k, word, sgn);
        end
        for (int j = 0; j < NB; j++) begin
            logic hit;
            hit = 1'b0;
            unique case (meth)
                M_ANY: begin
                    for (int i = 0; i < NB; i++)
                        if (i < la && j < lb && va[i] == vb[j])
                            hit = 1'b1;
                end
                M_RANGE: begin
                    for (int p = 0; p < NB / 2; p++)
                        if (2*p + 1 < la && j < lb &&
                            vb[j] >= va[2*p] && vb[j] <= va[2*p+1])
                            hit = 1'b1;
                end
                M_EACH: begin
                    if (j < la && j < lb)
                        hit = (va[j] == vb[j]);
                    else
                        hit = (j >= la && j >= lb);
                end
                M_ORDER: begin
                    hit = 1'b1;
                    for (int k = 0; k < NB; k++) begin
                        if (k < la) begin
                            if (j + k >= lb)
                                hit = 1'b0;
                            else if (va[k] != vb[(j + k) % NB])
                                hit = 1'b0;
                        end
                    end
                end
            endcase
            hits[j] = hit && (j < cnt);
        end
    end
endmodule

// File: rtl/pstr_reduce.sv
module pstr_reduce
    import pstr_pkg::*;
(
    input  logic [NB-1:0]     hits,
    input  logic              word,
    input  logic              sel_hi,
    input  logic              mask_form,
    output logic [IDXW-1:0]   idx,
    output logic [OPND_W-1:0] mask
);
    always_comb begin
        idx  = '0;
        mask = '0;
        if (!mask_form) begin
            idx = word ? IDXW'(NW) : IDXW'(NB);
            if (sel_hi) begin
                for (int k = 0; k < NB; k++)
                    if (hits[k]) idx = IDXW'(k);
            end else begin
                for (int k = NB - 1; k >= 0; k--)
                    if (hits[k]) idx = IDXW'(k);
            end
        end else if (!sel_hi) begin
            mask = OPND_W'(hits);
        end else begin
            for (int k = 0; k < NB; k++) begin
                if (word) begin
                    if (k < NW) mask[16*(k % NW) +: 16] = {16{hits[k]}};
                end else begin
                    mask[8*k +: 8] = {8{hits[k]}};
                end
            end
        end
    end
endmodule

// File: rtl/pstr_match_unit.sv
module pstr_match_unit
    import pstr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic [7:0]        ctrl,
    input  logic [OPND_W-1:0] opnd_a,
    input  logic [OPND_W-1:0] opnd_b,
    input  logic [LENW-1:0]   len_a,
    input  logic [LENW-1:0]   len_b,
    input  logic              implicit_len,
    input  logic              mask_form,
    output logic              res_valid,
    output logic [IDXW-1:0]   res_idx,
    output logic [OPND_W-1:0] res_mask
);
    state_e state_q, state_d;

    logic [7:0]        ctrl_q;
    logic [OPND_W-1:0] opnd_q [2];
    logic [LENW-1:0]   len_q  [2];
    logic              impl_q;
    logic              mform_q;

    logic [IDXW-1:0]   len_r [2];
    logic [NB-1:0]     hits;
    logic [IDXW-1:0]   idx_c;
    logic [OPND_W-1:0] mask_c;
    logic              unused_ctrl;

    assign unused_ctrl = ^{ctrl_q[7], ctrl_q[5:4]};

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = req ? ST_EVAL : ST_IDLE;
            ST_EVAL: state_d = req ? ST_EVAL : ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // Request capture.
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            impl_q  <= 1'b0;
            mform_q <= 1'b0;
            for (int s = 0; s < 2; s++) begin
                opnd_q[s] <= '0;
                len_q[s]  <= '0;
            end
        end else if (req) begin
            ctrl_q    <= ctrl;
            impl_q    <= implicit_len;
            mform_q   <= mask_form;
            opnd_q[0] <= opnd_a;
            opnd_q[1] <= opnd_b;
            len_q[0]  <= len_a;
            len_q[1]  <= len_b;
        end
    end

    for (genvar s = 0; s < 2; s++) begin : g_len
        pstr_len u_len (
            .opnd         (opnd_q[s]),
            .word         (ctrl_q[0]),
            .implicit_len (impl_q),
            .len_in       (len_q[s]),
            .len_out      (len_r[s])
        );
    end

    pstr_cmp u_cmp (
        .opnd_a (opnd_q[0]),
        .opnd_b (opnd_q[1]),
        .word   (ctrl_q[0]),
        .sgn    (ctrl_q[1]),
        .meth   (method_e'(ctrl_q[3:2])),
        .len_a  (len_r[0]),
        .len_b  (len_r[1]),
        .hits   (hits)
    );

    pstr_reduce u_red (
        .hits      (hits),
        .word      (ctrl_q[0]),
        .sel_hi    (ctrl_q[6]),
        .mask_form (mform_q),
        .idx       (idx_c),
        .mask      (mask_c)
    );

    // Output registers.
    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid <= 1'b0;
            res_idx   <= '0;
            res_mask  <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: res_valid <= 1'b0;
                ST_EVAL: begin
                    res_valid <= 1'b1;
                    res_idx   <= idx_c;
                    res_mask  <= mask_c;
                end
            endcase
        end
    end
endmodule

// File: rtl/pstr_match_chk.sv
module pstr_match_chk
    import pstr_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              req,
    input logic              res_valid,
    input logic [IDXW-1:0]   res_idx,
    input logic [OPND_W-1:0] res_mask
);
    p_reset_clear_r11: assert property (@(posedge clk)
        rst |=> (!res_valid && res_idx == '0 && res_mask == '0));

    p_req_gives_valid_r10: assert property (@(posedge clk) disable iff (rst)
        req |=> ##1 res_valid);

    p_valid_has_req_r10: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> $past(req, 2));

    p_form_exclusive_r8: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> (res_idx == '0 || res_mask == '0));

    p_idx_bound_r8: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> (res_idx <= IDXW'(NB)));
endmodule

bind pstr_match_unit pstr_match_chk u_chk (.*);

// File: tb/test_pstr_match_unit.sv
module test_pstr_match_unit;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         req = 1'b0;
    logic [7:0]   ctrl = '0;
    logic [127:0] opnd_a = '0, opnd_b = '0;
    logic [31:0]  len_a = '0, len_b = '0;
    logic         implicit_len = 1'b0, mask_form = 1'b0;
    logic         res_valid;
    logic [4:0]   res_idx;
    logic [127:0] res_mask;

    int nchk = 0;
    int nerr = 0;
    bit done = 0;
    string mtag [4] = '{"R2", "R3", "R4", "R5"};

    always #5 clk = ~clk;

    pstr_match_unit i_pstr_match_unit (.*);

    task automatic check_val(input string tag, input string what,
                             input logic [127:0] act, input logic [127:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic int bval(input logic [127:0] v, input int k, input logic [1:0] ty);
        if (ty[0]) return ty[1] ? int'($signed(v[16*k +: 16])) : int'(v[16*k +: 16]);
        return ty[1] ? int'($signed(v[8*k +: 8])) : int'(v[8*k +: 8]);
    endfunction

    function automatic int blen(input logic [127:0] v, input int raw, input logic impl,
                                input logic [1:0] ty);
        int n = ty[0] ? 8 : 16;
        longint m;
        if (impl) begin
            for (int k = 0; k < n; k++) if (bval(v, k, 2'b00 | ty[0]) == 0) return k;
            return n;
        end
        m = (raw < 0) ? -longint'(raw) : longint'(raw);
        return (m > n) ? n : int'(m);
    endfunction

    function automatic void model(input logic [7:0] c, input logic [127:0] a, b,
                                  input int ra, rb, input logic impl, msk,
                                  output int eidx, output logic [127:0] emask);
        int n = c[0] ? 8 : 16;
        int la = blen(a, ra, impl, c[1:0]);
        int lb = blen(b, rb, impl, c[1:0]);
        int av [16], bv [16];
        bit m [16];
        for (int k = 0; k < n; k++) begin
            av[k] = bval(a, k, c[1:0]);
            bv[k] = bval(b, k, c[1:0]);
        end
        for (int j = 0; j < n; j++) begin
            m[j] = 0;
            case (c[3:2])
                2'd0: for (int i = 0; i < la; i++) if (j < lb && av[i] == bv[j]) m[j] = 1;
                2'd1: for (int i = 0; i + 1 < la; i += 2)
                          if (j < lb && av[i] <= bv[j] && bv[j] <= av[i+1]) m[j] = 1;
                2'd2: m[j] = (j < la && j < lb) ? (av[j] == bv[j]) : (j >= la && j >= lb);
                default: begin
                    m[j] = 1;
                    for (int k = 0; k < la; k++)
                        if (j + k >= lb || av[k] != bv[j + k]) m[j] = 0;
                end
            endcase
        end
        eidx = 0;
        emask = '0;
        if (!msk) begin
            eidx = n;
            for (int j = 0; j < n; j++)
                if (m[j] && (c[6] || eidx == n)) eidx = j;
        end else begin
            for (int j = 0; j < n; j++) begin
                if (!c[6]) emask[j] = m[j];
                else if (c[0]) emask[16*j +: 16] = {16{m[j]}};
                else emask[8*j +: 8] = {8{m[j]}};
            end
        end
    endfunction

    task automatic drive(input logic [7:0] c, input logic [127:0] a, b,
                         input int ra, rb, input logic impl, msk);
        ctrl = c; opnd_a = a; opnd_b = b; len_a = ra; len_b = rb;
        implicit_len = impl; mask_form = msk; req = 1'b1;
    endtask

    task automatic run_chk(input string tag, input logic [7:0] c, input logic [127:0] a, b,
                           input int ra, rb, input logic impl, msk,
                           input int eidx, input logic [127:0] emask);
        drive(c, a, b, ra, rb, impl, msk);
        @(negedge clk); req = 1'b0;
        @(negedge clk);
        check_val(tag, "valid R10", 128'(res_valid), 128'(1));
        check_val(tag, "index", 128'(res_idx), 128'(eidx));
        check_val(tag, "mask", res_mask, emask);
        @(negedge clk);
        check_val(tag, "valid drop R10", 128'(res_valid), 128'(0));
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            nerr++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end

    initial begin : stim
        logic [127:0] hay;
        int ei;
        logic [127:0] em;
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        // R11: reset state
        check_val("R11", "valid", 128'(res_valid), 128'(0));
        check_val("R11", "index", 128'(res_idx), 128'(0));
        check_val("R11", "mask", res_mask, 128'(0));
        rst = 1'b0;
        @(negedge clk);

        hay = {{13{8'h78}}, 8'h61, 8'h62, 8'h78};
        run_chk("R2 first", 8'h00, 128'h6261, hay, 2, 16, 0, 0, 1, '0);
        run_chk("R8 last", 8'h40, 128'h6261, hay, 2, 16, 0, 0, 2, '0);
        run_chk("R9 packed", 8'h00, 128'h6261, hay, 2, 16, 0, 1, 0, 128'h6);
        run_chk("R3 unsigned", 8'h04, 128'h9010, 128'h20, 2, 1, 0, 0, 0, '0);
        run_chk("R12 signed byte", 8'h06, 128'h9010, 128'h20, 2, 1, 0, 0, 16, '0);
        run_chk("R12 signed word", 8'h07, 128'h0005_8000, 128'hFFFF, 2, 1, 0, 0, 0, '0);
        run_chk("R12 unsigned word", 8'h05, 128'h0005_8000, 128'hFFFF, 2, 1, 0, 0, 8, '0);
        run_chk("R4 lengths", 8'h08, {16{8'h33}}, {16{8'h33}}, 3, 5, 0, 1, 0, 128'hFFE7);
        run_chk("R5 first", 8'h0C, 128'h6261, 128'h62_61_62_61_7a, 0, 0, 1, 0, 1, '0);
        run_chk("R5 last", 8'h4C, 128'h6261, 128'h62_61_62_61_7a, 0, 0, 1, 0, 3, '0);
        run_chk("R7 mask", 8'h0C, 128'h6261, 128'h62_61_62_61_7a, 0, 0, 1, 1, 0, 128'hA);
        run_chk("R6 saturate", 8'h09, {16{8'h44}}, {16{8'h44}}, 100, -3, 0, 1, 0, 128'h07);
        run_chk("R9 expanded R1", 8'h49, {16{8'h44}}, {16{8'h44}}, 100, -3, 0, 1, 0,
                128'hFFFF_FFFF_FFFF);
        run_chk("R8 none word", 8'h01, 128'h1, 128'h1, 0, 8, 0, 0, 8, '0);
        run_chk("R6 most negative", 8'h08, {16{8'h21}}, {16{8'h21}}, 32'sh8000_0000, 16, 0, 1,
                0, 128'hFFFF);
        run_chk("R7 terminator", 8'h00, 128'h0063, 128'h63_78, 0, 0, 1, 0, 1, '0);

        // R10: back-to-back requests
        drive(8'h00, 128'h6261, hay, 2, 16, 0, 0);
        @(negedge clk);
        drive(8'h40, 128'h6261, hay, 2, 16, 0, 0);
        @(negedge clk); req = 1'b0;
        check_val("R10 b2b first", "valid", 128'(res_valid), 128'(1));
        check_val("R10 b2b first", "index", 128'(res_idx), 128'(1));
        @(negedge clk);
        check_val("R10 b2b second", "valid", 128'(res_valid), 128'(1));
        check_val("R10 b2b second", "index", 128'(res_idx), 128'(2));
        @(negedge clk);
        check_val("R10 b2b end", "valid", 128'(res_valid), 128'(0));
        check_val("R10 hold", "index", 128'(res_idx), 128'(2));

        // R11: reset while a request is in flight
        drive(8'h00, 128'h6261, hay, 2, 16, 0, 1);
        @(negedge clk); req = 1'b0; rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check_val("R11 flight", "valid", 128'(res_valid), 128'(0));
        check_val("R11 flight", "index", 128'(res_idx), 128'(0));
        check_val("R11 flight", "mask", res_mask, 128'(0));
        @(negedge clk);
        check_val("R11 no stray", "valid", 128'(res_valid), 128'(0));

        // Constrained random mix
        for (int it = 0; it < 400; it++) begin
            logic [127:0] ra, rb;
            logic [7:0] c;
            logic impl, msk;
            int xa, xb;
            for (int k = 0; k < 16; k++) begin
                int v = $urandom_range(0, 11);
                ra[8*k +: 8] = (v == 0) ? 8'h00 : (v < 8) ? 8'(8'h40 + v) : 8'(8'hC0 + v);
                v = $urandom_range(0, 11);
                rb[8*k +: 8] = (v == 0) ? 8'h00 : (v < 8) ? 8'(8'h40 + v) : 8'(8'hC0 + v);
            end
            c    = 8'($urandom);
            impl = 1'($urandom);
            msk  = 1'($urandom);
            xa   = $urandom_range(0, 40) - 20;
            xb   = $urandom_range(0, 40) - 20;
            model(c, ra, rb, xa, xb, impl, msk, ei, em);
            run_chk(mtag[c[3:2]], c, ra, rb, xa, xb, impl, msk, ei, em);
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule